// File: doc/BRIEF.md
# Serial Clock-Configuration Register Slave

This block is a two-wire serial slave that holds a small bank of byte-wide configuration registers for a clock synthesizer. A bus master addresses it with a 7-bit slave address and a direction bit. For a write, the master sends two leading bytes whose contents are discarded. Every following byte lands in the next register, starting at register 0. For a read, the slave streams register 0, register 1 and so on, most significant bit first, for as long as the master acknowledges. There is no register pointer. Every transaction begins at register 0.

One register, the frequency-select register at index 3, is decoded continuously. Its bit 3 chooses where the 3-bit frequency table index comes from. It is either a hardware speed pin or three software bits held at bits 6:4. Its bits 1:0 give a 2-bit output mode. The register contents change only through bus writes and the power-up reset. Bus start and stop conditions never clear them.

SCL and SDA are brought into the system clock through two-flop synchronizers. SDA is driven open-drain: the block only ever pulls it low.

Top module: `clkcfg_serial_regs`

## Requirements
- R1: Only the configured slave address (default 7'h69) is acknowledged. For any other address, SDA is never pulled low until the next start condition.
- R2: In a write, the first two bytes after the address are acknowledged and leave every register unchanged. A write that ends after them changes nothing.
- R3: Each later write byte is acknowledged and stored in register 0, then 1, then 2 and onward.
- R4: In a read (direction bit 1), the slave returns register 0, 1, 2 and onward, MSB first, one byte per master acknowledge.
- R5: When the master does not acknowledge a read byte, the slave releases SDA and drives nothing more until the next start.
- R6: Each start condition restarts the register sequence at register 0. Registers reset to 0 only on the power-up reset and keep their values across transactions.
- R7: Bytes written past the last register (NUM_REGS, default 8) are acknowledged but discarded. Reads past the last register return 8'h00.
- R8: When bit 3 of register 3 is 1, freqIdx equals bits 6:4 of register 3.
- R9: When bit 3 of register 3 is 0, freqIdx is 3'b111 while speedPin is high and 3'b011 while it is low.
- R10: outMode equals bits 1:0 of register 3. The encodings are 00 normal, 01 test, 10 spread spectrum and 11 tristate.
- R11: The slave releases SDA in the SCL low phase that follows each acknowledge it gives during a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low power-up reset |
| sclIn | input | 1 | Serial clock line, asynchronous |
| sdaIn | input | 1 | Serial data line as seen on the bus, asynchronous |
| sdaOe | output | 1 | When 1, the slave pulls SDA low |
| speedPin | input | 1 | Hardware speed select: high picks index 111, low picks 011 |
| freqIdx | output | 3 | Selected frequency table index |
| outMode | output | 2 | Output mode from register 3 bits 1:0 |

## Verification
A wrong register pointer shows up at the ports within one read transaction. The streamed bytes come back shifted or repeated against the model of what was written. A pointer that is not cleared at a start shows up on the first byte of the next read. A misdecoded frequency-select register appears on freqIdx or outMode a few system clocks after the acknowledge of the byte that wrote it. A control state that lingers after a missing master acknowledge or a foreign address is caught on the bus itself: SDA reads low while it should float high, during the very next bit.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_ADDR,
    S_ADDR_ACK,
    S_WR_BYTE,
    S_WR_ACK,
    S_RD_BYTE,
    S_RD_ACK
  } busStateT;

  // strobes from bus control to register bank, one cycle wide
  typedef struct packed {
    logic       ptrClr;
    logic       ptrInc;
    logic       wrEn;
    logic [7:0] wrData;
  } bankCmdT;

  localparam int unsigned SKIP_BYTES = 2;

endpackage

// File: rtl/clkcfg_sync.sv
module clkcfg_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned WIDTH  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chain <= {STAGES{RST_VAL}};
    end else begin
      chain[0] <= din;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/clkcfg_bus_ctrl.sv
module clkcfg_bus_ctrl
  import clkcfg_pkg::*;
#(
  parameter logic [6:0]  SLAVE_ADDR  = 7'h69,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [7:0] rdData,
  output bankCmdT    cmd,
  output logic       sdaOe
);
  localparam int unsigned BCW = 4;
  localparam int unsigned PHW = $clog2(SKIP_BYTES + 1);

  logic [1:0] syncOut;
  logic sclS, sdaS, sclD, sdaD;
  logic sclRise, sclFall, startDet, stopDet;

  busStateT         state;
  logic [BCW-1:0]   bitCnt;
  logic [7:0]       rxShift, txShift;
  logic [PHW-1:0]   wrPhase;
  logic             isRead, mAck;

  clkcfg_sync #(.STAGES(SYNC_STAGES), .WIDTH(2), .RST_VAL(2'b11)) uSync (
    .clk (clk),
    .rstN(rstN),
    .din ({sclIn, sdaIn}),
    .dout(syncOut)
  );
  assign {sclS, sdaS} = syncOut;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclD <= 1'b1;
      sdaD <= 1'b1;
    end else begin
      sclD <= sclS;
      sdaD <= sdaS;
    end
  end

  assign sclRise  = sclS & ~sclD;
  assign sclFall  = ~sclS & sclD;
  assign startDet = sclS & sclD & sdaD & ~sdaS;
  assign stopDet  = sclS & sclD & ~sdaD & sdaS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      bitCnt  <= '0;
      rxShift <= '0;
      txShift <= '0;
      wrPhase <= '0;
      isRead  <= 1'b0;
      mAck    <= 1'b0;
      sdaOe   <= 1'b0;
      cmd     <= '0;
    end else begin
      cmd.ptrClr <= 1'b0;
      cmd.ptrInc <= 1'b0;
      cmd.wrEn   <= 1'b0;
      if (startDet) begin
        state      <= S_ADDR;
        bitCnt     <= '0;
        wrPhase    <= '0;
        sdaOe      <= 1'b0;
        cmd.ptrClr <= 1'b1;
      end else if (stopDet) begin
        state <= S_IDLE;
        sdaOe <= 1'b0;
      end else begin
        unique case (state)
          S_IDLE: sdaOe <= 1'b0;
          S_ADDR: begin
            if (sclRise) begin
              rxShift <= {rxShift[6:0], sdaS};
              bitCnt  <= bitCnt + 1'b1;
            end else if (sclFall && bitCnt == BCW'(8)) begin
              if (rxShift[7:1] == SLAVE_ADDR) begin
                isRead <= rxShift[0];
                sdaOe  <= 1'b1;
                state  <= S_ADDR_ACK;
              end else begin
                state <= S_IDLE;
              end
            end
          end
          S_ADDR_ACK: begin
            if (sclFall) begin
              bitCnt <= '0;
              if (isRead) begin
                txShift <= rdData;
                sdaOe   <= ~rdData[7];
                state   <= S_RD_BYTE;
              end else begin
                sdaOe <= 1'b0;
                state <= S_WR_BYTE;
              end
            end
          end
          S_WR_BYTE: begin
            if (sclRise) begin
              rxShift <= {rxShift[6:0], sdaS};
              bitCnt  <= bitCnt + 1'b1;
            end else if (sclFall && bitCnt == BCW'(8)) begin
              sdaOe <= 1'b1;
              state <= S_WR_ACK;
              if (wrPhase == PHW'(SKIP_BYTES)) begin
                cmd.wrEn   <= 1'b1;
                cmd.wrData <= rxShift;
              end else begin
                wrPhase <= wrPhase + 1'b1;
              end
            end
          end
          S_WR_ACK: begin
            if (sclFall) begin
              sdaOe  <= 1'b0;
              bitCnt <= '0;
              state  <= S_WR_BYTE;
            end
          end
          S_RD_BYTE: begin
            if (sclRise) begin
              bitCnt <= bitCnt + 1'b1;
            end else if (sclFall) begin
              if (bitCnt == BCW'(8)) begin
                sdaOe      <= 1'b0;
                cmd.ptrInc <= 1'b1;
                state      <= S_RD_ACK;
              end else begin
                txShift <= {txShift[6:0], 1'b0};
                sdaOe   <= ~txShift[6];
              end
            end
          end
          S_RD_ACK: begin
            if (sclRise) begin
              mAck <= ~sdaS;
            end else if (sclFall) begin
              if (mAck) begin
                txShift <= rdData;
                sdaOe   <= ~rdData[7];
                bitCnt  <= '0;
                state   <= S_RD_BYTE;
              end else begin
                sdaOe <= 1'b0;
                state <= S_IDLE;
              end
            end
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE) |-> !sdaOe);

  // R11
  ack_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_WR_ACK && sclFall && !startDet && !stopDet) |=> !sdaOe);

  // R5
  nack_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_RD_ACK && sclFall && !mAck && !startDet && !stopDet)
      |=> (state == S_IDLE && !sdaOe));

endmodule

// File: rtl/clkcfg_reg_bank.sv
module clkcfg_reg_bank
  import clkcfg_pkg::*;
#(
  parameter int unsigned NUM_REGS = 8,
  parameter int unsigned FSEL_IDX = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  bankCmdT    cmd,
  input  logic       speedPin,
  output logic [7:0] rdData,
  output logic [2:0] freqIdx,
  output logic [1:0] outMode
);
  localparam int unsigned PW = $clog2(NUM_REGS + 1);

  logic [7:0]            regQ [NUM_REGS];
  logic [NUM_REGS*8-1:0] regFlat;
  logic [PW-1:0]         ptr;
  logic [7:0]            fsel;
  logic                  unusedFsel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr <= '0;
    end else if (cmd.ptrClr) begin
      ptr <= '0;
    end else if ((cmd.wrEn || cmd.ptrInc) && ptr != PW'(NUM_REGS)) begin
      ptr <= ptr + 1'b1;
    end
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : gReg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        regQ[g] <= 8'h00;
      end else if (cmd.wrEn && ptr == PW'(g)) begin
        regQ[g] <= cmd.wrData;
      end
    end
    assign regFlat[g*8 +: 8] = regQ[g];
  end

  always_comb begin
    rdData = 8'h00;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (ptr == PW'(i)) rdData = regQ[i];
    end
  end

  assign fsel       = regQ[FSEL_IDX];
  assign unusedFsel = fsel[7] ^ fsel[2];
  assign freqIdx    = fsel[3] ? fsel[6:4] : (speedPin ? 3'b111 : 3'b011);
  assign outMode    = fsel[1:0];

  // R6
  ptr_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmd.ptrClr |=> (ptr == '0));

  // R7
  ptr_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    ptr <= PW'(NUM_REGS));

  // R2
  reg_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cmd.wrEn |=> $stable(regFlat));

endmodule

// File: rtl/clkcfg_serial_regs.sv
module clkcfg_serial_regs
  import clkcfg_pkg::*;
#(
  parameter logic [6:0]  SLAVE_ADDR  = 7'h69,
  parameter int unsigned NUM_REGS    = 8,
  parameter int unsigned FSEL_IDX    = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  output logic       sdaOe,
  input  logic       speedPin,
  output logic [2:0] freqIdx,
  output logic [1:0] outMode
);
  bankCmdT    bankCmd;
  logic [7:0] rdData;

  clkcfg_bus_ctrl #(.SLAVE_ADDR(SLAVE_ADDR), .SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk   (clk),
    .rstN  (rstN),
    .sclIn (sclIn),
    .sdaIn (sdaIn),
    .rdData(rdData),
    .cmd   (bankCmd),
    .sdaOe (sdaOe)
  );

  clkcfg_reg_bank #(.NUM_REGS(NUM_REGS), .FSEL_IDX(FSEL_IDX)) uBank (
    .clk     (clk),
    .rstN    (rstN),
    .cmd     (bankCmd),
    .speedPin(speedPin),
    .rdData  (rdData),
    .freqIdx (freqIdx),
    .outMode (outMode)
  );
endmodule

// File: tb/tb_clkcfg_serial_regs.sv
module tb_clkcfg_serial_regs;
  localparam logic [6:0] ADDR = 7'h69;
  localparam int Q = 10;

  typedef struct {
    logic [7:0] val;
    string      tag;
  } expItemT;

  logic clk = 1'b0, rstN = 1'b0;
  logic mScl = 1'b1, mSdaLow = 1'b0, speedPin = 1'b1;
  logic sdaOe;
  logic [2:0] freqIdx;
  logic [1:0] outMode;
  wire  sdaLine = ~(mSdaLow | sdaOe);

  int total = 0, bad = 0;
  bit finished = 1'b0;
  logic [7:0] mdl [8];
  logic [7:0] wbuf [16];
  logic [7:0] obsByte;
  expItemT expQ [$];
  event obsEv;

  always #2 clk = ~clk;

  clkcfg_serial_regs dut (
    .clk(clk), .rstN(rstN), .sclIn(mScl), .sdaIn(sdaLine), .sdaOe(sdaOe),
    .speedPin(speedPin), .freqIdx(freqIdx), .outMode(outMode)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic waitQ(); repeat (Q) @(posedge clk); endtask

  task automatic busStart();
    mSdaLow = 1'b0; waitQ(); mScl = 1'b1; waitQ();
    mSdaLow = 1'b1; waitQ(); mScl = 1'b0; waitQ();
  endtask

  task automatic busStop();
    mSdaLow = 1'b1; waitQ(); mScl = 1'b1; waitQ(); mSdaLow = 1'b0; waitQ();
  endtask

  task automatic sendBit(input bit b);
    mSdaLow = ~b; waitQ(); mScl = 1'b1; waitQ(); waitQ(); mScl = 1'b0; waitQ();
  endtask

  task automatic readBit(output bit b);
    mSdaLow = 1'b0; waitQ(); mScl = 1'b1; waitQ();
    @(negedge clk); b = sdaLine;
    waitQ(); mScl = 1'b0; waitQ();
  endtask

  task automatic sendByte(input logic [7:0] v, output bit acked);
    bit line;
    for (int i = 7; i >= 0; i--) sendBit(v[i]);
    readBit(line);
    acked = ~line;
  endtask

  task automatic readByte(input bit giveAck, output logic [7:0] v);
    bit line;
    for (int i = 7; i >= 0; i--) begin readBit(line); v[i] = line; end
    sendBit(~giveAck);
  endtask

  // driver: write n data bytes after the two skipped bytes, update model
  task automatic writeRegs(input int n, input string tag);
    bit ack;
    busStart();
    sendByte({ADDR, 1'b0}, ack); check(ack, "R1 addr ack", ack, 1);
    sendByte(8'hA5, ack); check(ack, "R2 command byte ack", ack, 1);
    sendByte(8'h3C, ack); check(ack, "R2 count byte ack", ack, 1);
    for (int k = 0; k < n; k++) begin
      sendByte(wbuf[k], ack);
      check(ack, tag, ack, 1);
      if (k < 8) mdl[k] = wbuf[k];
    end
    busStop();
    repeat (8) @(posedge clk);
  endtask

  // driver: read n bytes, pushing expectations for the monitor
  task automatic readRegs(input int n);
    bit ack;
    logic [7:0] v;
    expItemT it;
    busStart();
    sendByte({ADDR, 1'b1}, ack); check(ack, "R1 read addr ack", ack, 1);
    for (int k = 0; k < n; k++) begin
      it.val = (k < 8) ? mdl[k] : 8'h00;
      it.tag = (k < 8) ? "R4 read sequence" : "R7 read past end";
      expQ.push_back(it);
      readByte(k < n - 1, v);
      obsByte = v;
      ->obsEv;
    end
    begin
      bit line;
      readBit(line);
      check(line == 1'b1, "R5 released after nack", line, 1);
    end
    busStop();
    repeat (8) @(posedge clk);
  endtask

  // monitor
  initial begin
    forever begin
      @(obsEv);
      if (expQ.size() == 0) begin
        check(1'b0, "R4 unexpected byte", obsByte, 0);
      end else begin
        expItemT it;
        it = expQ.pop_front();
        check(obsByte == it.val, it.tag, obsByte, it.val);
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      check(1'b0, "watchdog", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    bit ack;
    for (int i = 0; i < 8; i++) mdl[i] = 8'h00;
    repeat (5) @(posedge clk);
    rstN = 1'b1;
    repeat (5) @(posedge clk);
    @(negedge clk);
    check(sdaOe == 1'b0, "R1 reset sda released", sdaOe, 0);
    check(freqIdx == 3'b111, "R9 reset pin high", freqIdx, 3'b111);
    check(outMode == 2'b00, "R10 reset mode normal", outMode, 0);
    speedPin = 1'b0;
    @(negedge clk);
    check(freqIdx == 3'b011, "R9 pin low", freqIdx, 3'b011);

    // R3 basic write, reg3 = software select 110, spread mode
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33; wbuf[3] = 8'h6A;
    writeRegs(4, "R3 data ack");
    @(negedge clk);
    check(freqIdx == 3'b110, "R8 software select", freqIdx, 3'b110);
    check(outMode == 2'b10, "R10 spread mode", outMode, 2'b10);

    // R4 R6 read back from register 0
    readRegs(5);

    // R1 foreign address: no ack, no drive
    busStart();
    sendByte({7'h12, 1'b0}, ack); check(!ack, "R1 foreign addr not acked", ack, 0);
    sendByte(8'h00, ack); check(!ack, "R1 foreign data not acked", ack, 0);
    busStop();
    readRegs(4);

    // R2 write that ends after the two skipped bytes
    writeRegs(0, "R2 none");
    readRegs(4);

    // R7 overflow write, reg3 = pin select, tristate mode
    for (int k = 0; k < 9; k++) wbuf[k] = 8'(8'h80 + k);
    writeRegs(9, "R7 past-end byte ack");
    readRegs(9);
    @(negedge clk);
    check(freqIdx == 3'b011, "R9 pin select low", freqIdx, 3'b011);
    check(outMode == 2'b11, "R10 tristate mode", outMode, 2'b11);
    speedPin = 1'b1;
    @(negedge clk);
    check(freqIdx == 3'b111, "R9 pin select high", freqIdx, 3'b111);

    // R8 R10 sweep of modes and software indices
    for (int m = 0; m < 4; m++) begin
      for (int k = 0; k < 3; k++) wbuf[k] = 8'(8'h40 + m * 4 + k);
      wbuf[3] = {1'b0, 3'(m + 4), 1'b1, 1'b0, 2'(m)};
      writeRegs(4, "R3 sweep ack");
      @(negedge clk);
      check(freqIdx == 3'(m + 4), "R8 sweep index", freqIdx, m + 4);
      check(outMode == 2'(m), "R10 sweep mode", outMode, m);
    end
    readRegs(8);

    repeat (20) @(posedge clk);
    check(expQ.size() == 0, "R4 all expected bytes seen", expQ.size(), 0);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule